// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Controller

This block sits behind a serial front end that has already assembled 16-bit command words. It keeps two 14-bit code registers: a staging register that takes new data, and an output register whose value drives the converter. A 2-bit opcode in the top of each word chooses one of four actions: stage data only, stage and apply data in one step, apply the staged value, or run a control subcommand. A control subcommand can drive a general-purpose logic output, select the serial output timing mode, or request power-down.

Power-down can be requested by a level on a hardware request pin or by a subcommand. Both paths work only while the permit input is high. Dropping the request pin does not wake the block. It wakes on a falling edge of the permit input, or when a word applies data to the output register. While powered down, the output code does not change and the staging register still accepts data. An active-low clear input loads the output register with a preset, either zero or midscale depending on a select input, and drives the general-purpose output low.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. The reset release is synchronised through two flops. One cycle after the internal release, both code registers hold the preset value: 0x2000 if `preset_mid` is 1, else 0. At that point `user_out`, `alt_mode` and `sd_active` are 0, and the cycle ignores commands, clear and power-down requests.
- R2: A valid word with opcode `cmd_word[15:14]`=00 writes `cmd_word[13:0]` into the staging register and leaves `dac_code` unchanged.
- R3: Opcode 01 writes `cmd_word[13:0]` into both registers, so `dac_code` shows it on the next cycle.
- R4: Opcode 10 copies the staging register into the output register.
- R5: With opcode 11, subcommand `cmd_word[13:11]` 000 and 001 do nothing, 100 drives `user_out` low, and 101 drives it high.
- R6: With opcode 11, subcommand 110 sets `alt_mode` and 111 clears it.
- R7: Power-down is entered when `sd_allow` is high and either `sd_req` is high or subcommand 010/011 arrives. While `sd_allow` is low, neither path enters power-down.
- R8: `sd_req` going low does not end power-down. A falling edge of `sd_allow`, or opcode 01 or 10, ends it. An exit wins over an entry in the same cycle.
- R9: While in power-down, `dac_code` holds its value, the staging register still loads, `user_out` keeps its state, and clear does not alter `dac_code`.
- R10: `clr_n` low (outside power-down) loads the output register with the R1 preset and drives `user_out` low. Clear takes precedence over an opcode 01 or 10 in the same cycle, but the staging register still loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word qualifier, one cycle per word |
| cmd_word | input | 16 | Opcode [15:14], data or subcommand [13:0] |
| preset_mid | input | 1 | Preset select: 1 = midscale, 0 = zero |
| clr_n | input | 1 | Active-low clear |
| sd_req | input | 1 | Hardware power-down request (level) |
| sd_allow | input | 1 | Power-down permit; falling edge wakes |
| dac_code | output | 14 | Output register code |
| sd_active | output | 1 | Power-down / high-impedance flag |
| user_out | output | 1 | General-purpose logic output |
| alt_mode | output | 1 | Serial output timing mode flag |

## Verification
A corrupted staging register is not visible at once. It appears on `dac_code` at the first opcode-10 transfer, so the bench always follows staging writes with a transfer, both in and out of power-down. A wrong power-down flag shows on `sd_active` on the very next edge. A flag that wakes too early also shows as a `dac_code` change while a freeze is expected. Clear and preset mistakes show on `dac_code` and `user_out` one cycle after the stimulus. Every output is compared against a behavioural model on each clock.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  typedef enum logic [1:0] {
    OP_STAGE = 2'b00,
    OP_BOTH  = 2'b01,
    OP_XFER  = 2'b10,
    OP_CTRL  = 2'b11
  } op_e;

  typedef struct packed {
    logic stage;
    logic both;
    logic xfer;
    logic sw_sd;
    logic user_lo;
    logic user_hi;
    logic mode_alt;
    logic mode_def;
  } cmd_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_dbuf_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic [2:0] sub_i,
  output cmd_t       cmd_o
);
  op_e op;

  always_comb begin
    op    = op_e'(op_i);
    cmd_o = '0;
    if (valid_i) begin
      unique case (op)
        OP_STAGE: cmd_o.stage = 1'b1;
        OP_BOTH:  cmd_o.both  = 1'b1;
        OP_XFER:  cmd_o.xfer  = 1'b1;
        default: begin
          unique case (sub_i)
            3'b010, 3'b011: cmd_o.sw_sd    = 1'b1;
            3'b100:         cmd_o.user_lo  = 1'b1;
            3'b101:         cmd_o.user_hi  = 1'b1;
            3'b110:         cmd_o.mode_alt = 1'b1;
            3'b111:         cmd_o.mode_def = 1'b1;
            default:        ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/dac_sd_ctrl.sv
module dac_sd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic allow_i,
  input  logic pin_i,
  input  logic sw_sd_i,
  input  logic wake_cmd_i,
  output logic sd_o,
  output logic exit_o
);
  logic allow_q;
  logic sd_q, sd_d;
  logic enter;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) allow_q <= 1'b0;
    else        allow_q <= allow_i;
  end

  always_comb begin
    exit_o = (allow_q & ~allow_i) | wake_cmd_i;
    enter  = allow_i & (pin_i | sw_sd_i);
    sd_d   = sd_q;
    if (en_i) begin
      if (exit_o)     sd_d = 1'b0;
      else if (enter) sd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sd_q <= 1'b0;
    else        sd_q <= sd_d;
  end

  assign sd_o = sd_q;

  assert_lockout_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !allow_i && !sd_q) |=> !sd_q);

  assert_pin_low_no_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sd_q && allow_i && !wake_cmd_i) |=> sd_q);
endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         preset_mid_i,
  input  logic         clr_i,
  input  logic         sd_i,
  input  logic         exit_i,
  input  logic         stage_i,
  input  logic         both_i,
  input  logic         xfer_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] dac_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] stg_q, stg_d, dac_q, dac_d, preset;
  logic         freeze;

  always_comb begin
    preset = preset_mid_i ? MID : '0;
    freeze = sd_i & ~exit_i;
    stg_d  = stg_q;
    if (init_i)                stg_d = preset;
    else if (stage_i | both_i) stg_d = data_i;
    dac_d = dac_q;
    if (init_i)      dac_d = preset;
    else if (freeze) dac_d = dac_q;
    else if (clr_i)  dac_d = preset;
    else if (both_i) dac_d = data_i;
    else if (xfer_i) dac_d = stg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      dac_q <= '0;
    end else begin
      stg_q <= stg_d;
      dac_q <= dac_d;
    end
  end

  assign dac_o = dac_q;

  assert_sd_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && sd_i && !exit_i) |=> $stable(dac_q));

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && stage_i && !clr_i && !sd_i) |=> (stg_q == $past(data_i)) && $stable(dac_q));

  assert_clear_preset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && clr_i && !sd_i) |=> (dac_q == $past(preset)));
endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CODE_W+1:0] cmd_word,
  input  logic              preset_mid,
  input  logic              clr_n,
  input  logic              sd_req,
  input  logic              sd_allow,
  output logic [CODE_W-1:0] dac_code,
  output logic              sd_active,
  output logic              user_out,
  output logic              alt_mode
);
  import dac_dbuf_pkg::*;

  localparam int WORD_W = CODE_W + 2;
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic rs1_q, rs2_q, rst_sync;
  logic init_q;
  logic cmd_ok;
  cmd_t cmd;
  logic exit_w;
  logic clr_act;
  logic user_q, user_d, mode_q, mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sync = rs2_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) init_q <= 1'b1;
    else           init_q <= 1'b0;
  end

  assign cmd_ok  = cmd_valid & ~init_q;
  assign clr_act = ~clr_n & ~init_q;

  dac_cmd_decode u_dec (
    .valid_i (cmd_ok),
    .op_i    (cmd_word[WORD_W-1 -: 2]),
    .sub_i   (cmd_word[CODE_W-1 -: 3]),
    .cmd_o   (cmd)
  );

  dac_sd_ctrl u_sd (
    .clk        (clk),
    .rst_n      (rst_sync),
    .en_i       (~init_q),
    .allow_i    (sd_allow),
    .pin_i      (sd_req),
    .sw_sd_i    (cmd.sw_sd),
    .wake_cmd_i (cmd.both | cmd.xfer),
    .sd_o       (sd_active),
    .exit_o     (exit_w)
  );

  dac_code_regs #(.W(CODE_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync),
    .init_i       (init_q),
    .preset_mid_i (preset_mid),
    .clr_i        (clr_act),
    .sd_i         (sd_active),
    .exit_i       (exit_w),
    .stage_i      (cmd.stage),
    .both_i       (cmd.both),
    .xfer_i       (cmd.xfer),
    .data_i       (cmd_word[CODE_W-1:0]),
    .dac_o        (dac_code)
  );

  always_comb begin
    user_d = user_q;
    mode_d = mode_q;
    if (!init_q) begin
      if (clr_act)           user_d = 1'b0;
      else if (cmd.user_hi)  user_d = 1'b1;
      else if (cmd.user_lo)  user_d = 1'b0;
      if (cmd.mode_alt)      mode_d = 1'b1;
      else if (cmd.mode_def) mode_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      user_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      user_q <= user_d;
      mode_q <= mode_d;
    end
  end

  assign user_out = user_q;
  assign alt_mode = mode_q;

  assert_init_preset_R1: assert property (@(posedge clk) disable iff (!rst_sync)
    init_q |=> (dac_code == ($past(preset_mid) ? MID : '0)) && !user_out && !sd_active);

  assert_clear_user_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    (!init_q && !clr_n) |=> !user_out);

  assert_mode_set_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    (cmd.mode_alt) |=> alt_mode);

  assert_user_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    (sd_active && clr_n && !cmd.user_hi && !cmd.user_lo) |=> $stable(user_out));
endmodule

// File: tb/dac_dbuf_ctrl_tb.sv
module dac_dbuf_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [W+1:0]  cmd_word;
  logic          preset_mid, clr_n, sd_req, sd_allow;
  logic [W-1:0]  dac_code;
  logic          sd_active, user_out, alt_mode;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  // behavioural model state
  bit       m_s1, m_s2, m_init, m_sd, m_user, m_mode, m_aq;
  int       m_stg, m_dac;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_ctrl #(.CODE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .preset_mid(preset_mid), .clr_n(clr_n), .sd_req(sd_req), .sd_allow(sd_allow),
    .dac_code(dac_code), .sd_active(sd_active), .user_out(user_out), .alt_mode(alt_mode)
  );

  always @(posedge clk) begin
    int pre, data, op, sub;
    bit wake, enter, freeze;
    pre  = preset_mid ? 8192 : 0;
    data = int'(cmd_word[W-1:0]);
    op   = cmd_valid ? int'(cmd_word[W+1:W]) : -1;
    sub  = int'(cmd_word[W-1:W-3]);
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_init = 1; m_stg = 0; m_dac = 0;
      m_sd = 0; m_user = 0; m_mode = 0; m_aq = 0;
    end else begin
      if (m_s2) begin
        if (m_init) begin
          m_stg = pre; m_dac = pre; m_init = 0;
        end else begin
          wake   = (m_aq && !sd_allow) || op == 1 || op == 2;
          enter  = sd_allow && (sd_req || (op == 3 && (sub == 2 || sub == 3)));
          freeze = m_sd && !wake;
          if (!freeze) begin
            if (!clr_n)       m_dac = pre;
            else if (op == 1) m_dac = data;
            else if (op == 2) m_dac = m_stg;
          end
          if (op == 0 || op == 1) m_stg = data;
          if (wake)       m_sd = 0;
          else if (enter) m_sd = 1;
          if (!clr_n)                     m_user = 0;
          else if (op == 3 && sub == 5)   m_user = 1;
          else if (op == 3 && sub == 4)   m_user = 0;
          if (op == 3 && sub == 6)        m_mode = 1;
          else if (op == 3 && sub == 7)   m_mode = 0;
        end
        m_aq = sd_allow;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    total++;
    if (int'(dac_code) != m_dac || sd_active != m_sd || user_out != m_user || alt_mode != m_mode) begin
      bad++;
      $display("FAIL %s: act code=%h sd=%0d user=%0d mode=%0d exp code=%h sd=%0d user=%0d mode=%0d",
               cur_req, dac_code, sd_active, user_out, alt_mode, m_dac, m_sd, m_user, m_mode);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++;
      $display("FAIL watchdog: act cycles=%0d exp <50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int op, input int payload);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = {2'(op), 14'(payload)};
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ctrl(input int sub);
    send(3, sub << 11);
  endtask

  task automatic expect_code(input string req, input int exp);
    total++;
    if (int'(dac_code) != exp) begin
      bad++;
      $display("FAIL %s: act code=%h exp code=%h", req, dac_code, exp);
    end
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = '0;
    preset_mid = 1'b1; clr_n = 1'b1; sd_req = 1'b0; sd_allow = 1'b1;
    idle(3);
    cur_req = "R1";
    expect_code("R1", 0);
    expect_bit("R1", sd_active, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    expect_code("R1", 16'h2000);

    cur_req = "R2";
    send(0, 14'h1234);
    idle(1);
    expect_code("R2", 16'h2000);
    cur_req = "R4";
    send(2, 0);
    idle(1);
    expect_code("R4", 16'h1234);

    cur_req = "R3";
    send(1, 14'h3FFF);
    idle(1);
    expect_code("R3", 16'h3FFF);

    cur_req = "R5";
    ctrl(0); ctrl(1);
    expect_bit("R5", user_out, 1'b0);
    ctrl(5); idle(1);
    expect_bit("R5", user_out, 1'b1);
    ctrl(4); idle(1);
    expect_bit("R5", user_out, 1'b0);
    ctrl(5);

    cur_req = "R6";
    ctrl(6); idle(1);
    expect_bit("R6", alt_mode, 1'b1);
    ctrl(7); idle(1);
    expect_bit("R6", alt_mode, 1'b0);

    cur_req = "R7";
    @(negedge clk); sd_allow = 1'b0; sd_req = 1'b1;
    idle(3);
    ctrl(2);
    idle(1);
    expect_bit("R7", sd_active, 1'b0);
    @(negedge clk); sd_allow = 1'b1;
    idle(2);
    expect_bit("R7", sd_active, 1'b1);

    cur_req = "R8";
    @(negedge clk); sd_req = 1'b0;
    idle(3);
    expect_bit("R8", sd_active, 1'b1);
    send(1, 14'h0AAA);
    idle(1);
    expect_bit("R8", sd_active, 1'b0);
    expect_code("R8", 16'h0AAA);
    ctrl(3); idle(1);
    expect_bit("R8", sd_active, 1'b1);
    @(negedge clk); sd_allow = 1'b0;
    idle(2);
    expect_bit("R8", sd_active, 1'b0);
    @(negedge clk); sd_allow = 1'b1;
    sd_req = 1'b1;
    @(negedge clk);
    send(2, 0);
    idle(1);
    expect_bit("R8", sd_active, 1'b1);
    @(negedge clk); sd_req = 1'b0;

    cur_req = "R9";
    ctrl(2);
    send(0, 14'h0555);
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
    idle(2);
    expect_code("R9", 16'h0AAA);
    expect_bit("R9", sd_active, 1'b1);
    send(2, 0);
    idle(1);
    expect_code("R9", 16'h0555);
    expect_bit("R9", sd_active, 1'b0);

    cur_req = "R10";
    ctrl(5);
    @(negedge clk); preset_mid = 1'b0; clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
    idle(1);
    expect_code("R10", 0);
    expect_bit("R10", user_out, 1'b0);
    @(negedge clk); preset_mid = 1'b1; clr_n = 1'b0;
    cmd_valid = 1'b1; cmd_word = {2'b01, 14'h1111};
    @(negedge clk); clr_n = 1'b1; cmd_valid = 1'b0;
    idle(1);
    expect_code("R10", 16'h2000);
    send(2, 0);
    idle(1);
    expect_code("R10", 16'h1111);

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule